// File: doc/BRIEF.md
# Sectored Write-Back Cache Tag Store

This block holds the tags and per-sector status of a small direct-mapped cache. Each block is split into sectors. A cache line keeps one tag for all of its sectors, and one valid bit and one dirty bit for each sector. A line can therefore be only partly present. A write can make its own sector valid without bringing in the rest of the block.

A requester issues one lookup at a time through a valid/ready handshake. The store answers with a one-cycle response that says hit or miss.

Between the lookup and the response, the store may need the next memory level. It then issues these requests in order:

- Write-back requests, one for each dirty sector of a line it is replacing.
- A single sector fill request, when a read finds no valid copy of its sector.

Each request uses its own valid/ready handshake. A fill ends when the fill-done strobe arrives. The data arrays and the memory beyond these handshakes sit outside the block.

Top module: `sector_tag_store`

## Requirements
- R1: With the default parameters, the request address splits as follows, and bits [1:0] never change an outcome:
  - bits [9:6] are the tag;
  - bits [5:4] are the line index;
  - bits [3:2] are the sector.
- R2: A lookup hits only when the stored tag equals the address tag and the addressed sector is valid. A hit, and any write that needs no write-back, raises `resp_valid` two cycles after the request is accepted.
- R3: A write that hits marks its sector dirty. That sector is written back when the line is later replaced.
- R4: A write whose tag matches but whose sector is invalid reports a miss. It validates and dirties that sector with no fill request. A later read of that sector hits.
- R5: A read whose tag matches but whose sector is invalid issues one fill request for that sector only. Its address is {tag, index, sector, 2'b00}. After `fill_done`, the response is a miss and the sector becomes valid.
- R6: A tag mismatch on a line with dirty sectors issues one write-back per dirty sector, in ascending sector order. Each write-back address is {old tag, index, sector, 2'b00}, and each request holds steady until `wb_ready`.
- R7: On a tag mismatch, once any write-backs are done, the new tag is installed with every sector invalid and clean. A read then fills only its own sector.
- R8: A write miss on a mismatching tag allocates the line. Only the written sector is valid and dirty.
- R9: `req_ready` is high only while no lookup, write-back or fill is in progress. While a request is outstanding, new lookups are refused.
- R10: After reset every sector of every line is invalid and clean, and `req_ready` is high. No response, write-back or fill request is active.
- R11: `resp_valid` lasts exactly one cycle. `req_ready` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Store can accept a lookup |
| resp_valid | output | 1 | One-cycle lookup completion |
| resp_hit | output | 1 | Lookup hit (valid with resp_valid) |
| wb_valid | output | 1 | Write-back request for one dirty sector |
| wb_addr | output | ADDR_W | Sector-aligned write-back address |
| wb_ready | input | 1 | Next level takes the write-back |
| fill_req_valid | output | 1 | Sector fill request |
| fill_addr | output | ADDR_W | Sector-aligned fill address |
| fill_ready | input | 1 | Next level takes the fill request |
| fill_done | input | 1 | Fill data has been delivered |

## Verification
A lookup that needs no traffic answers on the second cycle after acceptance. The bench drives on falling edges and samples on falling edges. It counts those edges from the request and requires the response on exactly the second one.

When write-backs or fills are pending, the timing depends on the handshakes. The first write-back appears one cycle after the lookup stage. Each following write-back appears one cycle after the previous `wb_ready`. The response follows `fill_done` by one cycle. The bench replies to each request only after it has observed that request. It stalls every write-back for one cycle to show that the request is held. It compares the order of the requests and the final hit flag with a status model that it builds from the requirements.

// File: rtl/sector_tag_store.sv
module sector_tag_store #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 4,
  parameter int SEC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ready,
  input  logic              fill_done
);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int SECS    = 1 << SEC_W;
  localparam int LINES   = 1 << IDX_W;
  localparam int SLO     = OFF_W - SEC_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FREQ, S_FWAIT, S_RESP} st_t;

  st_t               st;
  logic              r_write, r_hit;
  logic [ADDR_W-1:0] r_addr;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [SECS-1:0]   vld_q [LINES];
  logic [SECS-1:0]   dty_q [LINES];

  function automatic logic [SEC_W-1:0] lowest(input logic [SECS-1:0] m);
    logic [SEC_W-1:0] r;
    r = '0;
    for (int i = SECS - 1; i >= 0; i--)
      if (m[i]) r = SEC_W'(i);
    return r;
  endfunction

  wire [TAG_W-1:0] r_tag   = r_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] r_idx   = r_addr[OFF_W +: IDX_W];
  wire [SEC_W-1:0] r_sec   = r_addr[SLO +: SEC_W];
  wire [TAG_W-1:0] cur_tag = tag_q[r_idx];
  wire [SECS-1:0]  cur_v   = vld_q[r_idx];
  wire [SECS-1:0]  cur_d   = dty_q[r_idx];
  wire             tag_eq  = cur_tag == r_tag;
  wire [SECS-1:0]  sec_bit = SECS'(1) << r_sec;
  wire [SEC_W-1:0] wb_sec  = lowest(cur_d);
  wire [SECS-1:0]  d_after = cur_d & ~(SECS'(1) << wb_sec);

  wire do_install = (st == S_LOOK && !tag_eq && cur_d == '0) ||
                    (st == S_WB && wb_ready && d_after == '0);

  assign req_ready      = st == S_IDLE;
  assign resp_valid     = st == S_RESP;
  assign resp_hit       = r_hit;
  assign wb_valid       = st == S_WB;
  assign wb_addr        = {cur_tag, r_idx, wb_sec, {SLO{1'b0}}};
  assign fill_req_valid = st == S_FREQ;
  assign fill_addr      = {r_tag, r_idx, r_sec, {SLO{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_hit   <= 1'b0;
      r_addr  <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        vld_q[i] <= '0;
        dty_q[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_write <= req_write;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (tag_eq) begin
            r_hit <= cur_v[r_sec];
            if (r_write) begin
              vld_q[r_idx] <= cur_v | sec_bit;
              dty_q[r_idx] <= cur_d | sec_bit;
              st <= S_RESP;
            end else begin
              st <= cur_v[r_sec] ? S_RESP : S_FREQ;
            end
          end else begin
            r_hit <= 1'b0;
            if (cur_d != '0) st <= S_WB;
          end
        end
        S_WB:    if (wb_ready) dty_q[r_idx] <= d_after;
        S_FREQ:  if (fill_ready) st <= S_FWAIT;
        S_FWAIT: if (fill_done) begin
          vld_q[r_idx] <= cur_v | sec_bit;
          st <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (do_install) begin
        tag_q[r_idx] <= r_tag;
        vld_q[r_idx] <= r_write ? sec_bit : '0;
        dty_q[r_idx] <= r_write ? sec_bit : '0;
        st <= r_write ? S_RESP : S_FREQ;
      end
    end
  end

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R6
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> !wb_valid || (wb_addr[OFF_W-1:SLO] > $past(wb_addr[OFF_W-1:SLO])));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_ready |=> fill_req_valid && $stable(fill_addr));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || fill_req_valid || resp_valid) |-> !req_ready);

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_valid, fill_req_valid, resp_valid, req_ready}));
endmodule

// File: tb/sector_tag_store_tb.sv
module sector_tag_store_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic       req_ready, resp_valid, resp_hit, wb_valid, fill_req_valid;
  logic [9:0] wb_addr, fill_addr;
  logic       wb_ready = 1'b0, fill_ready = 1'b0, fill_done = 1'b0;

  int vecs = 0, errs = 0;

  logic [3:0] m_tag [4];
  logic [3:0] m_v   [4];
  logic [3:0] m_d   [4];

  always #2 clk = ~clk;

  sector_tag_store u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_ready(wb_ready), .fill_req_valid(fill_req_valid), .fill_addr(fill_addr),
    .fill_ready(fill_ready), .fill_done(fill_done));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int t, input int i, input int s, input int b);
    return 10'((t << 6) | (i << 4) | (s << 2) | b);
  endfunction

  task automatic access(input bit w, input logic [9:0] a);
    int t, i, s, n_wb, got_wb, cyc;
    bit e_hit, e_fill, done, held, fill_pend, fill_seen;
    logic [9:0] e_wb [4];
    t = int'(a[9:6]); i = int'(a[5:4]); s = int'(a[3:2]);
    n_wb = 0; e_fill = 0;
    e_hit = (m_tag[i] == 4'(t)) && m_v[i][s];
    if (m_tag[i] != 4'(t)) begin
      for (int k = 0; k < 4; k++)
        if (m_d[i][k]) begin e_wb[n_wb] = mk(int'(m_tag[i]), i, k, 0); n_wb++; end
      m_tag[i] = 4'(t); m_v[i] = '0; m_d[i] = '0;
    end
    if (!e_hit && !w) e_fill = 1;
    m_v[i][s] = 1'b1;
    if (w) m_d[i][s] = 1'b1;

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; got_wb = 0; done = 0; held = 0; fill_pend = 0; fill_seen = 0;
    while (!done && cyc < 60) begin
      wb_ready = 1'b0; fill_ready = 1'b0; fill_done = 1'b0;
      if (fill_pend) begin fill_done = 1'b1; fill_pend = 0; end
      if (resp_valid) begin
        chk(resp_hit == e_hit, e_hit ? "R2 hit" : (w ? "R4/R8 write miss" : "R5/R7 read miss"),
            int'(resp_hit), int'(e_hit));
        chk(got_wb == n_wb, "R6 write-back count", got_wb, n_wb);
        chk(fill_seen == e_fill, "R5 fill requested", int'(fill_seen), int'(e_fill));
        if (n_wb == 0 && !e_fill) chk(cyc == 2, "R2 response latency", cyc, 2);
        done = 1;
      end else if (wb_valid) begin
        chk(req_ready == 1'b0, "R9 ready low during write-back", int'(req_ready), 0);
        chk(got_wb < n_wb && wb_addr == e_wb[got_wb], "R6 write-back address",
            int'(wb_addr), got_wb < n_wb ? int'(e_wb[got_wb]) : -1);
        if (!held) held = 1;
        else begin wb_ready = 1'b1; got_wb++; held = 0; end
      end else if (fill_req_valid) begin
        chk(req_ready == 1'b0, "R9 ready low during fill", int'(req_ready), 0);
        chk(fill_addr == mk(t, i, s, 0), "R5 fill address", int'(fill_addr), int'(mk(t, i, s, 0)));
        chk(!fill_seen, "R5 single fill", int'(fill_seen), 0);
        fill_ready = 1'b1; fill_seen = 1; fill_pend = 1;
      end
      @(negedge clk);
      cyc++;
    end
    wb_ready = 1'b0; fill_ready = 1'b0; fill_done = 1'b0;
    if (!done) chk(0, "R2 no response", cyc, 0);
    chk(resp_valid == 1'b0 && req_ready == 1'b1, "R11 one-cycle response",
        int'({resp_valid, req_ready}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [9:0] lf;
    for (int k = 0; k < 4; k++) begin m_tag[k] = '0; m_v[k] = '0; m_d[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    chk({resp_valid, wb_valid, fill_req_valid} == 3'b000, "R10 reset outputs idle",
        int'({resp_valid, wb_valid, fill_req_valid}), 0);

    access(0, mk(0, 0, 0, 0));   // R10 all invalid: tag 0 still misses
    access(0, mk(3, 1, 2, 1));   // R7 install and fill
    access(0, mk(3, 1, 2, 3));   // R1 byte bits ignored, R2 hit
    access(0, mk(3, 1, 0, 0));   // R5 sector fill
    access(1, mk(3, 1, 3, 0));   // R4 write validates sector without fill
    access(0, mk(3, 1, 3, 2));   // R4 later read hits
    access(1, mk(3, 1, 0, 1));   // R3 write hit dirties
    access(0, mk(5, 1, 1, 0));   // R6 write-backs of sectors 0 then 3
    access(0, mk(5, 1, 0, 0));   // R7 other sectors cleared
    access(1, mk(9, 2, 1, 0));   // R8 write allocate
    access(0, mk(9, 2, 2, 0));   // R8 only written sector valid
    access(0, mk(9, 2, 1, 2));   // R8 written sector hits
    access(1, mk(2, 2, 3, 0));   // R6 single write-back, R8 allocate

    for (int a = 0; a < 1024; a++) access(a[0] ^ a[5] ^ a[7], 10'(a));
    lf = 10'h1a5;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[8:0], lf[9] ^ lf[6]};
      access(lf[1], {2'b00, lf[9:2]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule